// File: doc/BRIEF.md
# Timed Edge Event Scheduler

This block places up to four edge events inside each pattern cycle of a timing formatter. Every edge slot holds an entry made of a 16-bit coarse delay, a 6-bit fine code and a 4-bit action code. A cycle-start strobe loads the entries into the slots. Each slot then counts base clock periods equal to its coarse delay and, when the count runs out, raises its event-valid output for one clock. It presents its action code and its fine code with that pulse. The fine code is not acted on here; it is handed to a later fine-delay stage, where each step is 1/64 of a base clock period.

Two static controls shape the behaviour. The generation enable turns every slot off. The source select picks which of two cycle-start strobes (primary or alternate) loads the slots. When the alternate source is selected, all compare-class actions (codes 0x7 to 0xF) are illegal and are downgraded to no action when the slot loads. The event outputs report every slot that fires in a given clock, along with the lowest-numbered firing slot.

Each slot is a three-state machine. The states are `SLOT_IDLE` (nothing pending), `SLOT_COUNT` (coarse count running) and `SLOT_FIRE` (the one clock in which the event is presented). The transitions are as follows:
- *load*: from any state on an effective strobe, to `SLOT_FIRE` when the delay is 0 and to `SLOT_COUNT` otherwise.
- *tick*: `SLOT_COUNT` to `SLOT_COUNT` while the remaining count is above 1.
- *expire*: `SLOT_COUNT` to `SLOT_FIRE` when the remaining count is 1.
- *retire*: `SLOT_FIRE` to `SLOT_IDLE`.
- *disable*: any state to `SLOT_IDLE` while the enable is low.

Top module: `edge_sched`

## Requirements
- R1: During and after reset, before any strobe, `ev_valid`, `ev_act`, `ev_fine`, `ev_any` and `ev_first` are all zero.
- R2: A strobe that is sampled at clock edge k loads each slot. Slot i loads with coarse delay N. `ev_valid[i]` is then high for exactly the one clock that follows edge k+N (N=0 gives the clock right after edge k). At that time `ev_act` slice i (bits 4i+3:4i) carries the loaded action code.
- R3: While `ev_valid[i]` is high, `ev_fine` slice i (bits 6i+5:6i) equals the loaded fine code unchanged. While `ev_valid[i]` is low, slice i of both `ev_act` and `ev_fine` is zero.
- R4: A slot whose loaded action is 0x0 (no action) never raises `ev_valid`.
- R5: While `gen_en` is low, all `ev_valid` bits are zero and strobes are ignored. A clock edge with `gen_en` low cancels every pending event.
- R6: With `src_sel`=0 only `cyc_prim` starts the slots. With `src_sel`=1 only `cyc_alt` starts them. The unselected strobe has no effect.
- R7: A slot loaded while `src_sel`=1 treats action codes 0x7 to 0xF (compare and window actions) as no action and does not fire. Codes 0x1 to 0x6 (drive low, drive high, force off, force on, force down, force up) fire normally.
- R8: A new effective strobe that arrives before a slot has fired restarts that slot with the new entry, and the earlier pending event is dropped.
- R9: When several slots fire in the same clock, all their `ev_valid` bits are high. `ev_any` is high, and `ev_first` holds the lowest index among them. With no slot firing, `ev_any` and `ev_first` are 0.
- R10: Slots count independently: each slot's fire time depends only on its own coarse delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Edge generation enable |
| src_sel | input | 1 | 0: primary strobe starts cycles; 1: alternate strobe, compare actions illegal |
| cyc_prim | input | 1 | Primary cycle-start strobe |
| cyc_alt | input | 1 | Alternate cycle-start strobe |
| ent_coarse | input | NSLOT*16 | Coarse delay per slot, slot i at bits 16i+15:16i |
| ent_fine | input | NSLOT*6 | Fine code per slot, slot i at bits 6i+5:6i |
| ent_act | input | NSLOT*4 | Action code per slot, slot i at bits 4i+3:4i |
| ev_valid | output | NSLOT | Per-slot event pulse |
| ev_act | output | NSLOT*4 | Per-slot action of the firing event |
| ev_fine | output | NSLOT*6 | Per-slot fine code of the firing event |
| ev_any | output | 1 | At least one slot fires |
| ev_first | output | clog2(NSLOT) | Lowest index of the firing slots |

## Verification
A slot stuck in the wrong state or with a wrong remaining count shows at the ports in one of three ways: a pulse in the wrong clock, a second pulse, or a missing pulse. Each is visible within at most coarse-delay-plus-one clocks of the strobe. A wrongly latched action or fine code shows at once in the firing clock. A missed downgrade in the alternate mode shows as a pulse that should not exist. The bench runs a cycle-by-cycle model of the expected countdowns and compares every output slice on every clock, so a mistimed or extra event is caught in the first clock where it differs.

// File: rtl/edge_sched_pkg.sv
package edge_sched_pkg;

    localparam int ACT_W = 4;

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE      = 4'h0,
        ACT_DRV_LO    = 4'h1,
        ACT_DRV_HI    = 4'h2,
        ACT_FRC_OFF   = 4'h3,
        ACT_FRC_ON    = 4'h4,
        ACT_FRC_DN    = 4'h5,
        ACT_FRC_UP    = 4'h6,
        ACT_CMP_LO    = 4'h7,
        ACT_CMP_HI    = 4'h8,
        ACT_CMP_OFF   = 4'h9,
        ACT_CMP_VLD   = 4'hA,
        ACT_WIN_LO    = 4'hB,
        ACT_WIN_HI    = 4'hC,
        ACT_WIN_Z     = 4'hD,
        ACT_WIN_VLD   = 4'hE,
        ACT_WIN_CLOSE = 4'hF
    } edge_act_e;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_COUNT = 2'd1,
        SLOT_FIRE  = 2'd2
    } slot_state_e;

    // Compare and window actions are downgraded in the alternate clocking mode.
    function automatic logic [ACT_W-1:0] legal_action(input logic [ACT_W-1:0] raw,
                                                      input logic alt_mode);
        if (alt_mode && (raw >= ACT_CMP_LO))
            return ACT_NONE;
        return raw;
    endfunction

endpackage

// File: rtl/edge_cycle_src.sv
module edge_cycle_src (
    input  logic gen_en,
    input  logic src_sel,
    input  logic cyc_prim,
    input  logic cyc_alt,
    output logic start,
    output logic alt_mode
);
    always_comb begin
        alt_mode = src_sel;
        start    = gen_en && (src_sel ? cyc_alt : cyc_prim);
    end
endmodule

// File: rtl/edge_slot.sv
module edge_slot
    import edge_sched_pkg::*;
#(
    parameter int CRS_W = 16,
    parameter int FIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             start,
    input  logic             alt_mode,
    input  logic [CRS_W-1:0] crs,
    input  logic [FIN_W-1:0] fin,
    input  logic [ACT_W-1:0] act,
    output logic             fire,
    output logic [ACT_W-1:0] fire_act,
    output logic [FIN_W-1:0] fire_fin
);
    localparam logic [CRS_W-1:0] CNT_ONE = CRS_W'(1);

    slot_state_e      state_q, state_d;
    logic [CRS_W-1:0] cnt_q, cnt_d;
    logic [ACT_W-1:0] act_q, act_d;
    logic [FIN_W-1:0] fin_q, fin_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        act_d   = act_q;
        fin_d   = fin_q;
        if (!gen_en) begin
            state_d = SLOT_IDLE;
        end else if (start) begin
            act_d   = legal_action(act, alt_mode);
            fin_d   = fin;
            cnt_d   = crs;
            state_d = (crs == '0) ? SLOT_FIRE : SLOT_COUNT;
        end else begin
            unique case (state_q)
                SLOT_IDLE:  state_d = SLOT_IDLE;
                SLOT_COUNT: begin
                    if (cnt_q == CNT_ONE)
                        state_d = SLOT_FIRE;
                    else
                        cnt_d = cnt_q - CNT_ONE;
                end
                SLOT_FIRE:  state_d = SLOT_IDLE;
                default:    state_d = SLOT_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            cnt_q   <= '0;
            act_q   <= '0;
            fin_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
            fin_q   <= fin_d;
        end
    end

    // outputs
    always_comb begin
        fire     = gen_en && (state_q == SLOT_FIRE) && (act_q != ACT_NONE);
        fire_act = fire ? act_q : '0;
        fire_fin = fire ? fin_q : '0;
    end
endmodule

// File: rtl/edge_fire_merge.sv
module edge_fire_merge #(
    parameter int NSLOT = 4
) (
    input  logic [NSLOT-1:0]         fire,
    output logic                     any,
    output logic [$clog2(NSLOT)-1:0] first
);
    localparam int IDX_W = $clog2(NSLOT);

    always_comb begin
        any   = |fire;
        first = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (fire[i])
                first = IDX_W'(i);
        end
    end
endmodule

// File: rtl/edge_sched.sv
module edge_sched
    import edge_sched_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int CRS_W = 16,
    parameter int FIN_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     gen_en,
    input  logic                     src_sel,
    input  logic                     cyc_prim,
    input  logic                     cyc_alt,
    input  logic [NSLOT*CRS_W-1:0]   ent_coarse,
    input  logic [NSLOT*FIN_W-1:0]   ent_fine,
    input  logic [NSLOT*ACT_W-1:0]   ent_act,
    output logic [NSLOT-1:0]         ev_valid,
    output logic [NSLOT*ACT_W-1:0]   ev_act,
    output logic [NSLOT*FIN_W-1:0]   ev_fine,
    output logic                     ev_any,
    output logic [$clog2(NSLOT)-1:0] ev_first
);
    logic start;
    logic alt_mode;

    edge_cycle_src u_src (
        .gen_en   (gen_en),
        .src_sel  (src_sel),
        .cyc_prim (cyc_prim),
        .cyc_alt  (cyc_alt),
        .start    (start),
        .alt_mode (alt_mode)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        edge_slot #(
            .CRS_W (CRS_W),
            .FIN_W (FIN_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .gen_en   (gen_en),
            .start    (start),
            .alt_mode (alt_mode),
            .crs      (ent_coarse[g*CRS_W +: CRS_W]),
            .fin      (ent_fine[g*FIN_W +: FIN_W]),
            .act      (ent_act[g*ACT_W +: ACT_W]),
            .fire     (ev_valid[g]),
            .fire_act (ev_act[g*ACT_W +: ACT_W]),
            .fire_fin (ev_fine[g*FIN_W +: FIN_W])
        );
    end

    edge_fire_merge #(
        .NSLOT (NSLOT)
    ) u_merge (
        .fire  (ev_valid),
        .any   (ev_any),
        .first (ev_first)
    );
endmodule

// File: rtl/edge_sched_chk.sv
module edge_sched_chk
    import edge_sched_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int CRS_W = 16,
    parameter int FIN_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     gen_en,
    input logic                     src_sel,
    input logic                     cyc_prim,
    input logic                     cyc_alt,
    input logic [NSLOT*CRS_W-1:0]   ent_coarse,
    input logic [NSLOT*FIN_W-1:0]   ent_fine,
    input logic [NSLOT*ACT_W-1:0]   ent_act,
    input logic [NSLOT-1:0]         ev_valid,
    input logic [NSLOT*ACT_W-1:0]   ev_act,
    input logic [NSLOT*FIN_W-1:0]   ev_fine,
    input logic                     ev_any,
    input logic [$clog2(NSLOT)-1:0] ev_first
);
    logic             eff_start;
    logic [NSLOT-1:0] below_first;
    logic             unused_ok;

    always_comb begin
        eff_start   = gen_en && (src_sel ? cyc_alt : cyc_prim);
        below_first = (NSLOT'(1) << ev_first) - NSLOT'(1);
        unused_ok   = ^{ent_coarse, ent_fine, ent_act};
    end

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |-> (ev_valid == '0));

    // R9
    first_is_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_any |-> ev_valid[ev_first]);

    // R9
    first_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_any |-> ((ev_valid & below_first) == '0));

    // R9
    idle_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_any |-> (ev_valid == '0 && ev_first == '0));

    for (genvar g = 0; g < NSLOT; g++) begin : g_chk
        // R4
        no_null_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_valid[g] |-> (ev_act[g*ACT_W +: ACT_W] != ACT_NONE));

        // R3
        quiet_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ev_valid[g] |-> (ev_act[g*ACT_W +: ACT_W] == '0 &&
                              ev_fine[g*FIN_W +: FIN_W] == '0));

        // R2
        single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_valid[g] && !eff_start) |=> !ev_valid[g]);

        // R7
        alt_no_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (eff_start && src_sel && ent_act[g*ACT_W +: ACT_W] >= ACT_CMP_LO)
                |=> !ev_valid[g]);
    end
endmodule

bind edge_sched edge_sched_chk #(
    .NSLOT (NSLOT),
    .CRS_W (CRS_W),
    .FIN_W (FIN_W)
) u_chk (.*);

// File: tb/edge_sched_test.sv
module edge_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int CW = 16;
    localparam int FW = 6;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gen_en = 1'b1;
    logic src_sel = 1'b0;
    logic cyc_prim = 1'b0;
    logic cyc_alt = 1'b0;
    logic [NS*CW-1:0] ent_coarse;
    logic [NS*FW-1:0] ent_fine;
    logic [NS*AW-1:0] ent_act;
    logic [NS-1:0]    ev_valid;
    logic [NS*AW-1:0] ev_act;
    logic [NS*FW-1:0] ev_fine;
    logic             ev_any;
    logic [1:0]       ev_first;

    logic [CW-1:0] crs [NS];
    logic [FW-1:0] fin [NS];
    logic [AW-1:0] act [NS];

    int           mcnt [NS];
    logic [AW-1:0] mact [NS];
    logic [FW-1:0] mfin [NS];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            ent_coarse[i*CW +: CW] = crs[i];
            ent_fine[i*FW +: FW]   = fin[i];
            ent_act[i*AW +: AW]    = act[i];
        end
    end

    edge_sched uut (.*);

    task automatic expect_eq(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] filt(input logic [AW-1:0] a, input logic alt);
        return (alt && a >= 4'h7) ? 4'h0 : a;
    endfunction

    task automatic check_outputs(input string tag);
        bit any_e = 0;
        int first_e = 0;
        for (int i = NS - 1; i >= 0; i--) begin
            bit v_e = gen_en && mcnt[i] == 0 && mact[i] != 0;
            expect_eq(tag, $sformatf("slot%0d valid", i), int'(ev_valid[i]), int'(v_e));
            expect_eq(tag, $sformatf("slot%0d act", i), int'(ev_act[i*AW +: AW]),
                      v_e ? int'(mact[i]) : 0);
            expect_eq(tag, $sformatf("slot%0d fine", i), int'(ev_fine[i*FW +: FW]),
                      v_e ? int'(mfin[i]) : 0);
            if (v_e) begin any_e = 1; first_e = i; end
        end
        expect_eq(tag, "any", int'(ev_any), int'(any_e));
        expect_eq(tag, "first", int'(ev_first), first_e);
    endtask

    // One clock: check now, optionally strobe, advance model over the edge.
    task automatic cycle(input bit p, input bit a, input string tag);
        bit eff;
        #1;
        check_outputs(tag);
        cyc_prim = p;
        cyc_alt  = a;
        eff = src_sel ? a : p;
        @(negedge clk);
        cyc_prim = 0;
        cyc_alt  = 0;
        for (int i = 0; i < NS; i++) begin
            if (!gen_en) mcnt[i] = -1;
            else if (eff) begin
                mcnt[i] = int'(crs[i]);
                mact[i] = filt(act[i], src_sel);
                mfin[i] = fin[i];
            end else if (mcnt[i] >= 0) mcnt[i]--;
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) cycle(0, 0, tag);
    endtask

    task automatic set_slot(input int i, input int c, input int f, input int a);
        crs[i] = CW'(c); fin[i] = FW'(f); act[i] = AW'(a);
    endtask

    task automatic t_reset;
        #1;
        expect_eq("R1", "valid in reset", int'(ev_valid), 0);
        expect_eq("R1", "any in reset", int'(ev_any), 0);
        expect_eq("R1", "act in reset", int'(ev_act), 0);
        @(negedge clk);
        rst_n = 1;
        idle(3, "R1");
    endtask

    task automatic t_timing;
        set_slot(0, 0, 6'h05, 1); set_slot(1, 3, 6'h3F, 2);
        set_slot(2, 5, 6'h00, 3); set_slot(3, 9, 6'h2A, 4);
        cycle(1, 0, "R2");
        idle(12, "R2 R3 R10");
    endtask

    task automatic t_noact;
        set_slot(0, 2, 6'h11, 0); set_slot(1, 2, 6'h12, 5);
        set_slot(2, 1, 6'h13, 0); set_slot(3, 4, 6'h14, 6);
        cycle(1, 0, "R4");
        idle(7, "R4");
    endtask

    task automatic t_multi;
        set_slot(0, 4, 1, 1); set_slot(1, 4, 2, 5);
        set_slot(2, 4, 3, 6); set_slot(3, 4, 4, 2);
        cycle(1, 0, "R9");
        idle(7, "R9");
        set_slot(0, 6, 9, 3); set_slot(1, 3, 8, 4);
        set_slot(2, 3, 7, 2); set_slot(3, 6, 6, 1);
        cycle(1, 0, "R9");
        idle(9, "R9");
    endtask

    task automatic t_disable;
        set_slot(0, 1, 1, 1); set_slot(1, 2, 2, 2);
        set_slot(2, 0, 3, 3); set_slot(3, 5, 4, 4);
        gen_en = 0;
        cycle(1, 0, "R5");
        idle(8, "R5");
        gen_en = 1;
        set_slot(0, 5, 1, 1); set_slot(1, 6, 2, 2);
        set_slot(2, 7, 3, 3); set_slot(3, 8, 4, 4);
        cycle(1, 0, "R5");
        idle(2, "R5");
        gen_en = 0;
        cycle(0, 0, "R5");
        gen_en = 1;
        idle(10, "R5");
    endtask

    task automatic t_srcsel;
        set_slot(0, 1, 10, 1); set_slot(1, 2, 11, 2);
        set_slot(2, 3, 12, 3); set_slot(3, 0, 13, 4);
        src_sel = 0;
        cycle(0, 1, "R6");
        idle(5, "R6");
        cycle(1, 0, "R6");
        idle(5, "R6");
        src_sel = 1;
        cycle(1, 0, "R6");
        idle(5, "R6");
        cycle(0, 1, "R6");
        idle(5, "R6");
        src_sel = 0;
    endtask

    task automatic t_altmode;
        set_slot(0, 1, 21, 4'h7); set_slot(1, 2, 22, 4'hB);
        set_slot(2, 3, 23, 4'hF); set_slot(3, 2, 24, 4'h6);
        src_sel = 1;
        cycle(0, 1, "R7");
        idle(6, "R7");
        set_slot(0, 1, 25, 4'hA); set_slot(1, 1, 26, 4'hE);
        set_slot(2, 2, 27, 4'h5); set_slot(3, 2, 28, 4'h8);
        cycle(0, 1, "R7");
        idle(5, "R7");
        src_sel = 0;
        set_slot(0, 1, 21, 4'h7); set_slot(1, 2, 22, 4'hB);
        set_slot(2, 3, 23, 4'hF); set_slot(3, 2, 24, 4'hD);
        cycle(1, 0, "R7");
        idle(6, "R7");
    endtask

    task automatic t_restart;
        set_slot(0, 8, 6'h01, 2); set_slot(1, 9, 6'h02, 1);
        set_slot(2, 4, 6'h03, 3); set_slot(3, 10, 6'h04, 4);
        cycle(1, 0, "R8");
        idle(3, "R8");
        set_slot(0, 2, 6'h21, 5); set_slot(1, 0, 6'h22, 6);
        set_slot(2, 3, 6'h23, 1); set_slot(3, 1, 6'h24, 2);
        cycle(1, 0, "R8");
        idle(14, "R8");
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin
            mcnt[i] = -1; mact[i] = 0; mfin[i] = 0;
            set_slot(i, 0, 0, 0);
        end
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_timing();
        t_noact();
        t_multi();
        t_disable();
        t_srcsel();
        t_altmode();
        t_restart();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired got 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule